// File: doc/BRIEF.md
# Scannable Level-Gated Storage Bank

This block holds a word of configurable width and behaves as a bank of level-gated D storage elements, emulated inside one clock domain. While the gate input is high, the output follows the data input in the same cycle, and the value is also written into the bank on every clock. When the gate is low, the bank keeps the last value it captured and the output shows that value.

Two asynchronous-style controls take over the output at once. Clear forces zeros. Set forces a configurable constant, or all ones when no constant is configured. Each control also writes its value into the bank, so the value remains after the control is released.

A test mode turns the bank into a shift chain. Each rising edge of the gate moves every bit one place toward the top, and the serial input enters at bit 0. The serial output always mirrors the top bit. Reset loads a configurable power-on word.

Top module: `latch_scan_bank`

## Requirements
- R1: While `rst_ni` is low, and on the first cycles after it rises with the gate low, `q_o` equals `PWR_VAL` (default 8'h3C).
- R2: With `gate_i`=1, `test_en_i`=0 and no clear or set, `q_o` equals `data_i` in the same cycle.
- R3: The bank stores `data_i` at each clock edge where `gate_i`=1, `test_en_i`=0 and no clear or set are active. After the gate falls, `q_o` holds the last value stored.
- R4: `clr_i`=1 forces `q_o` to all zeros in the same cycle, whatever `gate_i` and `test_en_i` are. The bank holds zero after `clr_i` is released.
- R5: `set_i`=1 (with `clr_i`=0) forces `q_o` to `SET_VAL` (default 8'hA5) when `SET_USE_VAL`=1, or to all ones otherwise. The bank holds that value after `set_i` is released.
- R6: With `test_en_i`=1 and no clear or set, each clock edge that sees `gate_i` high after it was low the cycle before shifts the bank: bit i moves to bit i+1 and `scan_i` enters bit 0. A gate held high gives exactly one shift, and `data_i` does not reach `q_o`.
- R7: `scan_o` always equals `q_o[WIDTH-1]`.
- R8: Priority order is clear, then set, then test shift, then gate load or hold. Clear and set together give an undefined value.
- R9: Changes on `data_i` while `gate_i`=0 do not change `q_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock used to emulate the storage |
| rst_ni | input | 1 | Active-low reset, loads the power-on word |
| data_i | input | WIDTH | Parallel data in |
| gate_i | input | 1 | High: transparent. Low: hold. Shift strobe in test mode |
| clr_i | input | 1 | Force all zeros |
| set_i | input | 1 | Force the set value |
| test_en_i | input | 1 | Selects shift-chain mode |
| scan_i | input | 1 | Serial input into bit 0 |
| scan_o | output | 1 | Serial output, top bit |
| q_o | output | WIDTH | Parallel output |

## Verification
Clear or set can arrive in the same cycle as a gate rising edge in test mode. They can also arrive while the gate is high in normal mode. The bench drives these cases directly, and then drives random mixes that never raise clear and set together. The judgement is that the forced value shows on `q_o` at once, and that the shift or load is not committed afterwards: once the control drops, the bank holds the forced value and not a shifted or loaded one.

// File: rtl/latch_scan_pkg.sv
package latch_scan_pkg;
  typedef enum logic [2:0] {
    MODE_CLR   = 3'd0,
    MODE_SET   = 3'd1,
    MODE_SHIFT = 3'd2,
    MODE_LOAD  = 3'd3,
    MODE_HOLD  = 3'd4
  } bank_mode_e;
endpackage

// File: rtl/lsb_edge.sv
module lsb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end
  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/lsb_mode_dec.sv
module lsb_mode_dec
  import latch_scan_pkg::*;
(
  input  logic       clr_i,
  input  logic       set_i,
  input  logic       test_en_i,
  input  logic       gate_i,
  input  logic       rise_i,
  output bank_mode_e mode_o
);
  always_comb begin
    if (clr_i)          mode_o = MODE_CLR;
    else if (set_i)     mode_o = MODE_SET;
    else if (test_en_i) mode_o = rise_i ? MODE_SHIFT : MODE_HOLD;
    else if (gate_i)    mode_o = MODE_LOAD;
    else                mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/lsb_store.sv
module lsb_store
  import latch_scan_pkg::*;
#(
  parameter int unsigned      WIDTH   = 8,
  parameter logic [WIDTH-1:0] PWR_VAL = '0,
  parameter logic [WIDTH-1:0] SET_EFF = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bank_mode_e       mode_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             scan_i,
  output logic [WIDTH-1:0] store_o
);
  logic [WIDTH-1:0] store_q, store_d;

  always_comb begin
    unique case (mode_i)
      MODE_CLR:   store_d = '0;
      MODE_SET:   store_d = SET_EFF;
      MODE_SHIFT: store_d = (store_q << 1) | WIDTH'(scan_i);
      MODE_LOAD:  store_d = data_i;
      default:    store_d = store_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) store_q <= PWR_VAL;
    else         store_q <= store_d;
  end

  assign store_o = store_q;
endmodule

// File: rtl/latch_scan_bank.sv
module latch_scan_bank
  import latch_scan_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter bit               SET_USE_VAL = 1'b1,
  parameter logic [WIDTH-1:0] SET_VAL     = WIDTH'(8'hA5),
  parameter logic [WIDTH-1:0] PWR_VAL     = WIDTH'(8'h3C)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             gate_i,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic             test_en_i,
  input  logic             scan_i,
  output logic             scan_o,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] SET_EFF = SET_USE_VAL ? SET_VAL : {WIDTH{1'b1}};

  logic             gate_rise;
  bank_mode_e       mode;
  logic [WIDTH-1:0] store_q;

  lsb_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  lsb_mode_dec i_dec (
    .clr_i     (clr_i),
    .set_i     (set_i),
    .test_en_i (test_en_i),
    .gate_i    (gate_i),
    .rise_i    (gate_rise),
    .mode_o    (mode)
  );

  lsb_store #(
    .WIDTH   (WIDTH),
    .PWR_VAL (PWR_VAL),
    .SET_EFF (SET_EFF)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .data_i  (data_i),
    .scan_i  (scan_i),
    .store_o (store_q)
  );

  // forced values and flow-through bypass the storage
  always_comb begin
    unique case (mode)
      MODE_CLR:  q_o = '0;
      MODE_SET:  q_o = SET_EFF;
      MODE_LOAD: q_o = data_i;
      default:   q_o = store_q;
    endcase
  end

  assign scan_o = q_o[WIDTH-1];
endmodule

// File: rtl/latch_scan_bank_chk.sv
module latch_scan_bank_chk #(
  parameter int unsigned      WIDTH       = 8,
  parameter bit               SET_USE_VAL = 1'b1,
  parameter logic [WIDTH-1:0] SET_VAL     = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             gate_i,
  input logic             clr_i,
  input logic             set_i,
  input logic             test_en_i,
  input logic             scan_i,
  input logic             scan_o,
  input logic [WIDTH-1:0] q_o,
  input logic [WIDTH-1:0] store_q
);
  localparam logic [WIDTH-1:0] SET_CHK = SET_USE_VAL ? SET_VAL : {WIDTH{1'b1}};

  p_scan_tap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_o == q_o[WIDTH-1]);

  p_flow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !test_en_i && !clr_i && !set_i) |-> q_o == data_i);

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !test_en_i && !clr_i && !set_i) |=> store_q == $past(data_i));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !test_en_i && !clr_i && !set_i) |=> store_q == $past(store_q));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> q_o == '0);

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |-> q_o == SET_CHK);

  p_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && test_en_i && $rose(gate_i) && !clr_i && !set_i)
      |=> store_q == (($past(store_q) << 1) | WIDTH'($past(scan_i))));

  p_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && !clr_i && !set_i) |-> q_o == store_q);
endmodule

bind latch_scan_bank latch_scan_bank_chk #(
  .WIDTH       (WIDTH),
  .SET_USE_VAL (SET_USE_VAL),
  .SET_VAL     (SET_VAL)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .gate_i    (gate_i),
  .clr_i     (clr_i),
  .set_i     (set_i),
  .test_en_i (test_en_i),
  .scan_i    (scan_i),
  .scan_o    (scan_o),
  .q_o       (q_o),
  .store_q   (store_q)
);

// File: tb/test_latch_scan_bank.sv
`timescale 1ns/1ps
module test_latch_scan_bank;
  localparam int W = 8;
  localparam logic [W-1:0] SETV = 8'hA5;
  localparam logic [W-1:0] PWRV = 8'h3C;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic gate_i = 1'b0, clr_i = 1'b0, set_i = 1'b0, test_en_i = 1'b0, scan_i = 1'b0;
  logic scan_o;
  logic [W-1:0] q_o;

  int total = 0;
  int bad = 0;
  int mstore;
  bit mgprev;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  latch_scan_bank i_latch_scan_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .gate_i(gate_i),
    .clr_i(clr_i), .set_i(set_i), .test_en_i(test_en_i), .scan_i(scan_i),
    .scan_o(scan_o), .q_o(q_o)
  );

  function automatic int exp_q();
    if (clr_i) return 0;
    if (set_i) return int'(SETV);
    if (!test_en_i && gate_i) return int'(data_i);
    return mstore;
  endfunction

  task automatic check(string tag);
    int e;
    e = exp_q();
    total++;
    if (int'(q_o) != e) begin
      bad++;
      $display("FAIL %s q_o actual=%02h expected=%02h", tag, q_o, e);
    end
    total++;
    if (scan_o != e[W-1]) begin
      bad++;
      $display("FAIL R7 (%s) scan_o actual=%0b expected=%0b", tag, scan_o, e[W-1]);
    end
  endtask

  task automatic step(bit c, bit s, bit t, bit g, bit si, logic [W-1:0] d, string tag);
    @(negedge clk_i);
    clr_i = c; set_i = s; test_en_i = t; gate_i = g; scan_i = si; data_i = d;
    #2;
    check(tag);
    @(posedge clk_i);
    if (c) mstore = 0;
    else if (s) mstore = int'(SETV);
    else if (t) begin
      if (g && !mgprev) mstore = ((mstore << 1) | int'(si)) & 'hFF;
    end else if (g) mstore = int'(d);
    mgprev = g;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mstore = int'(PWRV);
    mgprev = 1'b0;
    repeat (3) @(posedge clk_i);
    #2; check("R1 reset");
    @(negedge clk_i); rst_ni = 1'b1;
    step(0,0,0,0,0,8'h00,"R1 after reset");
    step(0,0,0,0,0,8'hFF,"R9 data moves gate low");
    step(0,0,0,0,0,8'h12,"R9 data moves gate low");
    step(0,0,0,1,0,8'h5A,"R2 flow");
    step(0,0,0,1,0,8'hC3,"R2 flow change");
    step(0,0,0,0,0,8'h99,"R3 hold after fall");
    step(0,0,0,0,0,8'h01,"R3 hold");
    step(0,1,0,0,0,8'h00,"R5 set");
    step(0,0,0,0,0,8'h77,"R5 held after set");
    step(1,0,1,1,1,8'hFF,"R4 R8 clear over test and gate");
    step(0,0,0,0,0,8'hEE,"R4 held zero");
    step(0,0,0,1,0,8'h81,"R2 load");
    step(0,0,1,0,1,8'hFF,"R6 test idle");
    step(0,0,1,1,1,8'hFF,"R6 shift edge");
    step(0,0,1,1,0,8'h00,"R6 gate held no second shift");
    step(0,0,1,1,0,8'h00,"R6 gate held");
    step(0,0,1,0,0,8'h00,"R6 gate low");
    step(0,0,1,1,0,8'h00,"R6 shift zero");
    for (int k = 0; k < 8; k++) begin
      step(0,0,1,0,1,8'h00,"R6 pulse low");
      step(0,0,1,1,k[0],8'h00,"R6 R7 pulse shift");
    end
    step(0,0,1,0,0,8'h00,"R6 low");
    step(0,1,1,1,1,8'h00,"R8 set beats shift edge");
    step(0,0,1,0,0,8'h00,"R8 no shift committed");
    step(1,0,0,1,0,8'h44,"R8 clear beats load");
    step(0,0,0,0,0,8'h44,"R8 no load committed");
    for (int k = 0; k < 300; k++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      step(a == 3'd0, a == 3'd1, 1'($urandom), 1'($urandom), 1'($urandom),
           8'($urandom), "R8 random mix");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule